// File: doc/BRIEF.md
# Always-On Wake Interrupt Controller

This block sits in an always-on power domain and gathers wake sources for two consumers. The first source is a dedicated non-maskable interrupt pin. Its trigger (either level or either edge) is chosen by a two-bit control field. The detected event sets pending bit 0, which is a sticky latch. That latch, gated by enable bit 0, drives a level-high interrupt line toward the main processor's interrupt controller.

Up to 31 further peripheral lines are captured on their rising edges into the same pending register. These lines reach the main processor on their own path outside this block, so here they only contribute to a single combined request toward a power-management coprocessor. That request is the OR of every pending source that is enabled, not masked and not marked in service.

Software reaches the block through a simple register port. Read data is a combinational decode of the address. A read strobe on the vector address reports the lowest-numbered active source and marks it in service.

Top module: `aon_wake_intc`

## Requirements
- R1: After reset every register reads zero, including the vector register at 0x00, and both interrupt outputs are low.
- R2: The trigger field is bits [1:0] at 0x0C: 0 means the pin is low, 1 a falling edge, 2 the pin is high, 3 a rising edge. A pin change that does not match the selected trigger leaves pending bit 0 clear.
- R3: Pending bit 0 (bit 0 at 0x10) stays set until a write with data bit 0 equal to 1. Writing 0 leaves it set. When a detection and a clearing write fall in the same cycle, the bit stays set.
- R4: `nmi_irq_o` is high exactly while pending bit 0 and enable bit 0 (bit 0 at 0x40) are both 1. Enable bits 1 and up never affect it.
- R5: A rising edge on `irq_in[i]` sets pending bit i. Writing 1 to that bit clears it, and the bit is not set again while the input stays high.
- R6: `coproc_req_o` is high exactly when some bit is set in pending AND enable AND NOT mask (0x50) AND NOT response (0x60).
- R7: The vector register reads as base (0x04) plus 4 times the lowest index whose pending, enable and unmasked bits are all set. It reads as the base alone when no such index exists. Response bits do not affect it.
- R8: A read strobe on 0x00 while a source is active sets that source's response bit. Writing 1 to a response bit clears it. A source with its response bit set does not drive `coproc_req_o`.
- R9: The base, enable and mask registers read back what was written. An unmapped address reads zero, and a write to it changes no register.
- R10: The pin synchronizer resets to the idle-high level, so the default low-level trigger does not fire while the pin is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_in | input | NUM_SRC-1 | Asynchronous peripheral interrupt lines, indices 1 and up |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe for read side effects, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| nmi_irq_o | output | 1 | Level-high interrupt to the main processor |
| coproc_req_o | output | 1 | Combined interrupt request to the coprocessor |

## Verification
The hardest case to reach is a detection that coincides with a clearing write to pending bit 0. From the ports this cannot be timed reliably through the two-flop synchronizer. The stimulus instead holds the pin at the active level in level-high mode, so that detection repeats every cycle. It then issues the clearing write and expects the bit to stay set. The in-service path is reached by strobing the vector with two sources pending. The bench then checks that the request only drops after the second source is also marked, and that it returns once one response bit is cleared.

// File: rtl/aon_intc_pkg.sv
package aon_intc_pkg;

   typedef enum logic [1:0] {
      TRIG_LVL_LO = 2'd0,
      TRIG_FALL   = 2'd1,
      TRIG_LVL_HI = 2'd2,
      TRIG_RISE   = 2'd3
   } nmi_trig_e;

   localparam logic [7:0] OFS_VEC  = 8'h00;
   localparam logic [7:0] OFS_BASE = 8'h04;
   localparam logic [7:0] OFS_NCTL = 8'h0C;
   localparam logic [7:0] OFS_PEND = 8'h10;
   localparam logic [7:0] OFS_EN   = 8'h40;
   localparam logic [7:0] OFS_MSK  = 8'h50;
   localparam logic [7:0] OFS_RSP  = 8'h60;

endpackage

// File: rtl/aon_sync.sv
module aon_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("aon_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/aon_nmi_detect.sv
module aon_nmi_detect
   import aon_intc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  nmi_trig_e mode,
   output logic      hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   always_comb begin
      unique case (mode)
         TRIG_LVL_LO: hit = ~lvl;
         TRIG_FALL:   hit = prev_q & ~lvl;
         TRIG_LVL_HI: hit = lvl;
         TRIG_RISE:   hit = ~prev_q & lvl;
         default:     hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/aon_rise_bank.sv
module aon_rise_bank #(
   parameter int W = 31
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/aon_low_find.sv
module aon_low_find #(
   parameter int W     = 32,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/aon_wake_intc.sv
module aon_wake_intc
   import aon_intc_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                nmi_pin,
   input  logic [NUM_SRC-1:1]  irq_in,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                nmi_irq_o,
   output logic                coproc_req_o
);
   localparam int IDX_W = $clog2(NUM_SRC);
   localparam int PER_W = NUM_SRC - 1;

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("aon_wake_intc: NUM_SRC must lie in 2..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("aon_wake_intc: ADDR_W must cover offset 0x60");
   end
   if (DATA_W < NUM_SRC || DATA_W < IDX_W + 2) begin : g_bad_data
      $error("aon_wake_intc: DATA_W too narrow");
   end

   // synchronizers: the pin idles high, peripherals idle low
   logic             nmi_s;
   logic [PER_W-1:0] per_s;

   aon_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
      .clk(clk), .rst_n(rst_n), .d(nmi_pin), .q(nmi_s)
   );
   aon_sync #(.W(PER_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_per (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(per_s)
   );

   // registers
   logic [DATA_W-1:0]  base_q;
   nmi_trig_e          nctl_q;
   logic [NUM_SRC-1:0] pend_q, en_q, msk_q, rsp_q;

   // event detection
   logic             nmi_hit;
   logic [PER_W-1:0] per_rise;

   aon_nmi_detect u_nmi_det (
      .clk(clk), .rst_n(rst_n), .lvl(nmi_s), .mode(nctl_q), .hit(nmi_hit)
   );
   aon_rise_bank #(.W(PER_W)) u_rise (
      .clk(clk), .rst_n(rst_n), .lvl(per_s), .rise(per_rise)
   );

   logic [NUM_SRC-1:0] evt;
   assign evt = {per_rise, nmi_hit};

   // decode
   logic wr_base, wr_nctl, wr_pend, wr_en, wr_msk, wr_rsp, rd_vec;
   assign wr_base = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_BASE));
   assign wr_nctl = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_NCTL));
   assign wr_pend = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_PEND));
   assign wr_en   = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_EN));
   assign wr_msk  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_MSK));
   assign wr_rsp  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_RSP));
   assign rd_vec  = bus_sel & bus_rd & (bus_addr == ADDR_W'(OFS_VEC));

   // lowest active source
   logic [NUM_SRC-1:0] active;
   logic               found;
   logic [IDX_W-1:0]   idx;

   assign active = pend_q & en_q & ~msk_q;

   aon_low_find #(.W(NUM_SRC), .IDX_W(IDX_W)) u_find (
      .req(active), .found(found), .idx(idx)
   );

   logic [DATA_W-1:0] vec;
   assign vec = found ? base_q + DATA_W'({idx, 2'b00}) : base_q;

   logic [NUM_SRC-1:0] pend_clr, rsp_clr, rsp_set;
   assign pend_clr = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;
   assign rsp_clr  = wr_rsp  ? bus_wdata[NUM_SRC-1:0] : '0;
   assign rsp_set  = (rd_vec && found) ? (NUM_SRC'(1) << idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         nctl_q <= TRIG_LVL_LO;
         pend_q <= '0;
         en_q   <= '0;
         msk_q  <= '0;
         rsp_q  <= '0;
      end else begin
         if (wr_base) base_q <= bus_wdata;
         if (wr_nctl) nctl_q <= nmi_trig_e'(bus_wdata[1:0]);
         if (wr_en)   en_q   <= bus_wdata[NUM_SRC-1:0];
         if (wr_msk)  msk_q  <= bus_wdata[NUM_SRC-1:0];
         pend_q <= (pend_q & ~pend_clr) | evt;
         rsp_q  <= (rsp_q & ~rsp_clr) | rsp_set;
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_VEC):  bus_rdata = vec;
         ADDR_W'(OFS_BASE): bus_rdata = base_q;
         ADDR_W'(OFS_NCTL): bus_rdata = DATA_W'(nctl_q);
         ADDR_W'(OFS_PEND): bus_rdata = DATA_W'(pend_q);
         ADDR_W'(OFS_EN):   bus_rdata = DATA_W'(en_q);
         ADDR_W'(OFS_MSK):  bus_rdata = DATA_W'(msk_q);
         ADDR_W'(OFS_RSP):  bus_rdata = DATA_W'(rsp_q);
         default:           bus_rdata = '0;
      endcase
   end

   assign nmi_irq_o    = pend_q[0] & en_q[0];
   assign coproc_req_o = |(active & ~rsp_q);

endmodule

// File: rtl/aon_wake_intc_chk.sv
module aon_wake_intc_chk
   import aon_intc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               nmi_irq_o,
   input logic               coproc_req_o,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] rsp_q,
   input logic               found
);
   logic wr_pend_c, wr_en_c, rd_vec_c;
   assign wr_pend_c = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_PEND));
   assign wr_en_c   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_EN));
   assign rd_vec_c  = bus_sel && bus_rd && (bus_addr == ADDR_W'(OFS_VEC));

   // R3 / R5: a pending bit only drops after a write to the pending register
   assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend_q) & ~pend_q)) |-> $past(wr_pend_c));

   // R4: the main-CPU line only falls after software touches pending or enable
   assert_nmi_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_irq_o) |-> $past(wr_pend_c || wr_en_c));

   // R6: a coprocessor request implies the vector finder sees an active source
   assert_req_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      coproc_req_o |-> found);

   // R8: response bits are only set by a vector read strobe with a source active
   assert_rsp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rsp_q & ~$past(rsp_q))) |-> $past(rd_vec_c && found));

   // R8: at most one response bit is set per cycle
   assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_q & ~$past(rsp_q)));
endmodule

bind aon_wake_intc aon_wake_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .nmi_irq_o(nmi_irq_o), .coproc_req_o(coproc_req_o),
   .pend_q(pend_q), .rsp_q(rsp_q), .found(found)
);

// File: tb/aon_wake_intc_test.sv
`timescale 1ns/1ps
module aon_wake_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_pin = 1'b1;
   logic [31:1] irq_in = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        nmi_irq_o, coproc_req_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   aon_wake_intc uut (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_in(irq_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .nmi_irq_o(nmi_irq_o), .coproc_req_o(coproc_req_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic strobe_vec(output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = 8'h00;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_vec(input logic [31:0] p, input logic [31:0] e,
                                           input logic [31:0] m, input logic [31:0] b);
      logic [31:0] a = p & e & ~m;
      for (int i = 0; i < 32; i++) if (a[i]) return b + 32'(4 * i);
      return b;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, exp_pend, en, msk, sub, clr;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      foreach (uut.pend_q[i]) ;
      peek(8'h00, d); check("R1 vector", d, 0);
      peek(8'h04, d); check("R1 base", d, 0);
      peek(8'h0C, d); check("R1 nctl", d, 0);
      peek(8'h40, d); check("R1 enable", d, 0);
      peek(8'h50, d); check("R1 mask", d, 0);
      peek(8'h60, d); check("R1 resp", d, 0);
      check("R1 nmi_irq_o", {31'b0, nmi_irq_o}, 0);
      check("R1 coproc_req_o", {31'b0, coproc_req_o}, 0);
      // R10 default low-level trigger, pin high: nothing pending
      settle();
      peek(8'h10, d); check("R10 pend idle", d, 0);

      // R9 register access
      wr(8'h04, 32'h0000_1000); peek(8'h04, d); check("R9 base rb", d, 32'h1000);
      wr(8'h50, 32'hA5A5_0000); peek(8'h50, d); check("R9 mask rb", d, 32'hA5A5_0000);
      wr(8'h40, 32'h0000_0001); peek(8'h40, d); check("R9 enable rb", d, 1);
      wr(8'h20, 32'hFFFF_FFFF);
      peek(8'h20, d); check("R9 unmapped read", d, 0);
      peek(8'h40, d); check("R9 unmapped write en", d, 1);
      peek(8'h50, d); check("R9 unmapped write msk", d, 32'hA5A5_0000);
      wr(8'h50, 0);

      // R2 rising mode
      wr(8'h0C, 3); wr(8'h10, 1);
      nmi_pin = 0; settle();
      peek(8'h10, d); check("R2 rise ignores fall", d, 0);
      nmi_pin = 1; settle();
      peek(8'h10, d); check("R2 rise sets", d, 1);
      check("R4 nmi high", {31'b0, nmi_irq_o}, 1);
      wr(8'h10, 0); peek(8'h10, d); check("R3 write0 keeps", d, 1);
      wr(8'h10, 1); settle(); peek(8'h10, d); check("R3 w1c clears", d, 0);
      check("R4 nmi low", {31'b0, nmi_irq_o}, 0);
      // falling mode
      wr(8'h0C, 1); nmi_pin = 0; settle();
      peek(8'h10, d); check("R2 fall sets", d, 1);
      wr(8'h10, 1); settle(); peek(8'h10, d); check("R2 fall cleared", d, 0);
      // level high mode, set wins
      wr(8'h0C, 2); settle();
      peek(8'h10, d); check("R2 lvlhi idle", d, 0);
      nmi_pin = 1; settle();
      peek(8'h10, d); check("R2 lvlhi sets", d, 1);
      wr(8'h10, 1); peek(8'h10, d); check("R3 set wins over clear", d, 1);
      nmi_pin = 0; settle(); wr(8'h10, 1); settle();
      peek(8'h10, d); check("R2 lvlhi cleared", d, 0);
      // level low mode
      wr(8'h0C, 0); settle();
      peek(8'h10, d); check("R2 lvllo sets", d, 1);
      nmi_pin = 1; settle(); wr(8'h10, 1); settle();
      peek(8'h10, d); check("R2 lvllo cleared", d, 0);
      // R4 enable gating
      wr(8'h0C, 1); nmi_pin = 0; settle();
      wr(8'h40, 0); check("R4 en0 off", {31'b0, nmi_irq_o}, 0);
      wr(8'h40, 32'hFFFF_FFFE); check("R4 upper en no effect", {31'b0, nmi_irq_o}, 0);
      wr(8'h40, 1); check("R4 en0 on", {31'b0, nmi_irq_o}, 1);
      wr(8'h0C, 3); wr(8'h10, 1); settle();
      peek(8'h10, d); check("R4 cleanup", d, 0);

      // R5 peripheral edges
      irq_in[5] = 1; settle();
      peek(8'h10, d); check("R5 rise sets bit5", d, 32'h20);
      wr(8'h10, 32'h20); settle();
      peek(8'h10, d); check("R5 held no reset", d, 0);
      irq_in[5] = 0; irq_in[31] = 1; irq_in[1] = 1; settle();
      irq_in[31] = 0; irq_in[1] = 0; settle();
      peek(8'h10, d); check("R5 bits 31 and 1", d, 32'h8000_0002);
      wr(8'h10, 32'hFFFF_FFFF);

      // R6 R7 R8
      wr(8'h40, 32'hFFFF_FFFF); wr(8'h50, 0);
      irq_in[3] = 1; irq_in[9] = 1; settle();
      irq_in[3] = 0; irq_in[9] = 0; settle();
      peek(8'h00, d); check("R7 vector idx3", d, 32'h100C);
      check("R6 req", {31'b0, coproc_req_o}, 1);
      wr(8'h50, 32'h8); peek(8'h00, d); check("R7 masked -> idx9", d, 32'h1024);
      wr(8'h50, 0);
      strobe_vec(d); check("R8 strobe returns idx3", d, 32'h100C);
      peek(8'h60, d); check("R8 resp bit3", d, 32'h8);
      check("R8 req from bit9", {31'b0, coproc_req_o}, 1);
      peek(8'h00, d); check("R7 resp ignored by vector", d, 32'h100C);
      wr(8'h10, 32'h8);
      strobe_vec(d); check("R8 strobe idx9", d, 32'h1024);
      peek(8'h60, d); check("R8 resp 3 and 9", d, 32'h208);
      check("R8 req blocked", {31'b0, coproc_req_o}, 0);
      wr(8'h60, 32'h200); check("R8 resp w1c restores req", {31'b0, coproc_req_o}, 1);
      wr(8'h40, 0); check("R6 req no enable", {31'b0, coproc_req_o}, 0);
      peek(8'h00, d); check("R7 vector base", d, 32'h1000);
      wr(8'h10, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);

      // random phase
      exp_pend = 0;
      for (int it = 0; it < 30; it++) begin
         en  = $urandom() & 32'hFFFF_FFFE;
         msk = $urandom() & $urandom();
         wr(8'h40, en); wr(8'h50, msk);
         sub = $urandom() & $urandom() & 32'hFFFF_FFFE;
         irq_in = sub[31:1]; settle();
         irq_in = '0; settle();
         exp_pend = exp_pend | sub;
         peek(8'h10, d); check("R5 rand pend", d, exp_pend);
         peek(8'h00, d); check("R7 rand vector", d, exp_vec(exp_pend, en, msk, 32'h1000));
         check("R6 rand req", {31'b0, coproc_req_o}, {31'b0, |(exp_pend & en & ~msk)});
         check("R4 rand nmi", {31'b0, nmi_irq_o}, 0);
         clr = $urandom();
         wr(8'h10, clr);
         exp_pend = exp_pend & ~clr;
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule